// File: doc/BRIEF.md
# Non-Blocking Skip-on-Not-Ready Process Node

This block wraps a small synchronous state machine so that it runs as an independent process on a platform built from finite queues. Each node owns one bounded queue for every incoming link. It receives a local trigger that may arrive at any rate. On a trigger, the node checks whether it can run. It needs a token waiting on every incoming queue, and room in the queue of the node downstream. If both hold, the node runs one step. It consumes one token from each input, updates its state and emits one output token, all in the same cycle. If either condition fails, the node does nothing for that trigger and pulses a skip flag. The wrapper never stalls and never waits.

The depth of each input queue follows from a single fact: whether the link carries a unit delay. A plain link has a one-entry queue, which starts empty. A delayed link has a two-entry queue. At reset it is loaded with one token that holds a configured initial value, so the first value read from it is that value. Any loop in a network must pass through at least one delayed link.

Networks are built by joining the output of one node to an input of another. When every link is sized by this rule, each link carries the same sequence of values as a lock-step synchronous run of the same machines. This holds whatever pattern the triggers follow. The state machine inside is a running accumulator. Its output is the old sum plus all input tokens, modulo 2^W, and that output also becomes the new sum.

Top module: `snr_proc_node`

## Requirements
- R1: A plain (non-delayed) input link queue holds exactly one token. Its empty flag (bit i of `in_empty`) is 1 out of reset. Its full flag (bit i of `in_full`) becomes 1 after one put that is not matched by a get.
- R2: A delayed input link queue holds two tokens. At reset it holds one token carrying `INIT_VAL`, so out of reset its empty flag is 0 and its full flag is 0. The first token the node consumes from it is `INIT_VAL`.
- R3: When `trig` is 1, every input queue is non-empty and `out_full` is 0, the node fires in that cycle. `fired` is 1, one token is taken from every input queue, and `out_put` is 1 with the result on `out_data`.
- R4: When `trig` is 1 and the fire condition of R3 is false, `skipped` is 1 for that cycle. `out_put` is 0, no input token is removed and the accumulator keeps its value.
- R5: When `trig` is 0, `fired`, `skipped` and `out_put` are all 0, and no queue or state changes apart from puts from upstream.
- R6: A firing step outputs `acc + sum of the consumed input tokens` modulo 2^W, and `acc` takes that value. `acc` is 0 after reset.
- R7: The node never takes a token from an empty queue. An upstream node never puts into a full queue when it obeys `in_full`.
- R8: In a network sized by the depth rule, the k-th token emitted on each link equals the k-th value of the same link in a lock-step synchronous run. This holds under any trigger pattern, including all-ones, random and slow ones.
- R9: In such a network, whenever every input queue of a node is non-empty, that node's `out_full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads delayed queues with INIT_VAL |
| trig | input | 1 | Local trigger: one step attempt per cycle in which it is 1 |
| in_put | input | NI | Per-input put strobe from the upstream producer |
| in_data | input | NI*W | Per-input token, input i in bits [i*W +: W] |
| in_full | output | NI | Per-input queue full flag, seen by the upstream producer |
| in_empty | output | NI | Per-input queue empty flag |
| out_full | input | 1 | Full flag of the downstream queue this node writes |
| out_put | output | 1 | Put strobe to the downstream queue |
| out_data | output | W | Output token |
| fired | output | 1 | The step ran this cycle |
| skipped | output | 1 | A trigger arrived but the step could not run |

## Verification
The queue assertions assume that every producer puts only while the matching full flag is low. The bench source meets this by putting only when its model of the queue shows room. The nodes meet it through the fire gate. The assertion that outputs are never full while all inputs hold tokens depends on the network: it holds only when every loop carries one delayed link and each queue has the depth the rule gives. The bench therefore builds a two-node ring with exactly one delayed edge. All triggers are held low during reset, so the preloaded token is the only one present when reset is released.

// File: rtl/snr_pkg.sv
package snr_pkg;

   typedef enum logic {
      LINK_PLAIN   = 1'b0,
      LINK_DELAYED = 1'b1
   } link_kind_e;

   // queue depth that preserves the synchronous semantics of a link
   function automatic int link_depth(link_kind_e kind);
      return (kind == LINK_DELAYED) ? 2 : 1;
   endfunction

endpackage

// File: rtl/lq_fifo.sv
module lq_fifo
   import snr_pkg::*;
#(
   parameter int              W       = 8,
   parameter bit              DELAYED = 1'b0,
   parameter logic [W-1:0]    INIT    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         put,
   input  logic [W-1:0] put_data,
   input  logic         get,
   output logic [W-1:0] get_data,
   output logic         is_empty,
   output logic         is_full
);

   localparam link_kind_e KIND  = DELAYED ? LINK_DELAYED : LINK_PLAIN;
   localparam int         DEPTH = link_depth(KIND);

   generate
      if (DEPTH == 1) begin : g_one
         logic         vld_q;
         logic [W-1:0] slot_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q  <= 1'b0;
               slot_q <= '0;
            end else if (put && !vld_q) begin
               slot_q <= put_data;
               vld_q  <= 1'b1;
            end else if (get && vld_q) begin
               vld_q  <= 1'b0;
            end
         end

         assign get_data = slot_q;
         assign is_empty = !vld_q;
         assign is_full  = vld_q;
      end else begin : g_two
         logic [W-1:0] mem_q [2];
         logic         rd_q;
         logic         wr_q;
         logic [1:0]   cnt_q;
         logic         do_put;
         logic         do_get;

         assign do_put = put && (cnt_q != 2'd2);
         assign do_get = get && (cnt_q != 2'd0);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem_q[0] <= DELAYED ? INIT : '0;
               mem_q[1] <= '0;
               rd_q     <= 1'b0;
               wr_q     <= DELAYED;
               cnt_q    <= DELAYED ? 2'd1 : 2'd0;
            end else begin
               if (do_put) begin
                  mem_q[wr_q] <= put_data;
                  wr_q        <= ~wr_q;
               end
               if (do_get) rd_q <= ~rd_q;
               cnt_q <= cnt_q + 2'(do_put) - 2'(do_get);
            end
         end

         assign get_data = mem_q[rd_q];
         assign is_empty = (cnt_q == 2'd0);
         assign is_full  = (cnt_q == 2'd2);

         // R2: token preloaded for the unit delay is present when reset ends
         p_preload_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (!is_empty && get_data == INIT));
      end
   endgenerate

   // R7: producers respect the full flag, consumers the empty flag
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      put |-> !is_full);
   p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      get |-> !is_empty);

endmodule

// File: rtl/fire_gate.sv
module fire_gate #(
   parameter int NI = 2
) (
   input  logic          trig,
   input  logic [NI-1:0] in_empty,
   input  logic          out_full,
   output logic          fire,
   output logic          skip
);

   logic ready;

   always_comb begin
      ready = !out_full;
      for (int i = 0; i < NI; i++) begin
         if (in_empty[i]) ready = 1'b0;
      end
      fire = trig && ready;
      skip = trig && !ready;
   end

endmodule

// File: rtl/mealy_accum.sv
module mealy_accum #(
   parameter int NI = 2,
   parameter int W  = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   input  logic [NI*W-1:0] tokens,
   output logic [W-1:0]    y
);

   logic [W-1:0] acc_q;

   always_comb begin
      y = acc_q;
      for (int i = 0; i < NI; i++) begin
         y = y + tokens[i*W +: W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc_q <= '0;
      else if (step) acc_q <= y;
   end

   // R4: a cycle without a firing step leaves the machine state untouched
   p_hold_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(acc_q));

endmodule

// File: rtl/snr_proc_node.sv
module snr_proc_node
   import snr_pkg::*;
#(
   parameter int            NI         = 2,
   parameter int            W          = 8,
   parameter logic [NI-1:0] DELAY_MASK = '0,
   parameter logic [W-1:0]  INIT_VAL   = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trig,
   input  logic [NI-1:0]   in_put,
   input  logic [NI*W-1:0] in_data,
   output logic [NI-1:0]   in_full,
   output logic [NI-1:0]   in_empty,
   input  logic            out_full,
   output logic            out_put,
   output logic [W-1:0]    out_data,
   output logic            fired,
   output logic            skipped
);

   localparam int TOK_W = NI * W;

   generate
      if (NI < 1) begin : g_bad_ni
         $error("snr_proc_node: NI must be at least 1");
      end
      if (W < 1) begin : g_bad_w
         $error("snr_proc_node: W must be at least 1");
      end
   endgenerate

   logic [TOK_W-1:0] tokens;
   logic             fire;

   generate
      for (genvar i = 0; i < NI; i++) begin : g_link
         lq_fifo #(
            .W       (W),
            .DELAYED (DELAY_MASK[i]),
            .INIT    (INIT_VAL)
         ) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .put      (in_put[i]),
            .put_data (in_data[i*W +: W]),
            .get      (fire),
            .get_data (tokens[i*W +: W]),
            .is_empty (in_empty[i]),
            .is_full  (in_full[i])
         );
      end
   endgenerate

   fire_gate #(.NI(NI)) u_gate (
      .trig     (trig),
      .in_empty (in_empty),
      .out_full (out_full),
      .fire     (fire),
      .skip     (skipped)
   );

   mealy_accum #(.NI(NI), .W(W)) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (fire),
      .tokens (tokens),
      .y      (out_data)
   );

   assign out_put = fire;
   assign fired   = fire;

   // R9: with rule-sized queues a node holding all inputs never sees a full output
   p_sized_net_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (&(~in_empty)) |-> !out_full);

endmodule

// File: tb/snr_proc_node_tb.sv
module snr_proc_node_tb;

   localparam int W    = 8;
   localparam int NREF = 2600;
   localparam logic [W-1:0] INIT_A = 8'h5A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic         trig_a = 1'b0, trig_b = 1'b0;
   logic         src_put = 1'b0;
   logic [W-1:0] src_data = '0;

   logic [1:0]   a_in_full, a_in_empty;
   logic         a_out_put, a_fired, a_skipped;
   logic [W-1:0] a_out_data;
   logic [0:0]   b_in_full, b_in_empty;
   logic         b_out_put, b_fired, b_skipped;
   logic [W-1:0] b_out_data;

   // node A: input 0 from the bench (plain), input 1 fed back from B (delayed)
   snr_proc_node #(.NI(2), .W(W), .DELAY_MASK(2'b10), .INIT_VAL(INIT_A)) u_dut (
      .clk(clk), .rst_n(rst_n), .trig(trig_a),
      .in_put({b_out_put, src_put}), .in_data({b_out_data, src_data}),
      .in_full(a_in_full), .in_empty(a_in_empty),
      .out_full(b_in_full[0]), .out_put(a_out_put), .out_data(a_out_data),
      .fired(a_fired), .skipped(a_skipped));

   // node B: plain input from A, output closes the loop into A
   snr_proc_node #(.NI(1), .W(W), .DELAY_MASK(1'b0), .INIT_VAL(8'h00)) u_peer (
      .clk(clk), .rst_n(rst_n), .trig(trig_b),
      .in_put(a_out_put), .in_data(a_out_data),
      .in_full(b_in_full), .in_empty(b_in_empty),
      .out_full(a_in_full[1]), .out_put(b_out_put), .out_data(b_out_data),
      .fired(b_fired), .skipped(b_skipped));

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic logic [W-1:0] xval(input int k);
      return W'((k * 7 + 3) % 256);
   endfunction

   logic [W-1:0] ref_a [NREF];
   logic [W-1:0] ref_b [NREF];

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] qa0[$], qa1[$], qb0[$];
      logic [W-1:0] acc_a, acc_b, va, vb, ra, rb, fb;
      int sidx, na, nb;
      bit ea, eb;

      // lock-step synchronous reference of the ring
      ra = '0; rb = '0; fb = INIT_A;
      for (int k = 0; k < NREF; k++) begin
         ref_a[k] = ra + xval(k) + fb;
         ra = ref_a[k];
         ref_b[k] = rb + ref_a[k];
         rb = ref_b[k];
         fb = ref_b[k];
      end

      acc_a = '0; acc_b = '0; sidx = 0; na = 0; nb = 0;
      qa1.push_back(INIT_A);

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1, R2: reset occupancy of plain and delayed queues
      chk(a_in_empty == 2'b01, "R1/R2 reset empty flags A", int'(a_in_empty), 1);
      chk(a_in_full == 2'b00, "R1/R2 reset full flags A", int'(a_in_full), 0);
      chk(b_in_empty == 1'b1, "R1 reset empty flag B", int'(b_in_empty), 1);
      chk(!a_fired && !a_skipped && !b_fired && !b_skipped, "R5 idle at reset",
          int'({a_fired, a_skipped, b_fired, b_skipped}), 0);

      for (int t = 0; t < 2400; t++) begin
         @(negedge clk);
         if (t < 400) begin
            trig_a = 1'b1; trig_b = 1'b1; src_put = 1'b1;
         end else if (t < 1200) begin
            trig_a = 1'($urandom % 2); trig_b = 1'($urandom % 2);
            src_put = 1'($urandom % 2);
         end else if (t < 1400) begin
            trig_a = 1'b0; trig_b = 1'b0; src_put = 1'b1;
         end else begin
            trig_a = 1'b1; trig_b = (t % 3 == 0); src_put = 1'($urandom % 4 != 0);
         end
         if (qa0.size() != 0 || sidx >= NREF) src_put = 1'b0;
         src_data = xval(sidx);
         #1;

         ea = trig_a && qa0.size() > 0 && qa1.size() > 0 && qb0.size() < 1;
         eb = trig_b && qb0.size() > 0 && qa1.size() < 2;

         chk(a_fired == ea, "R3 fire decision A", int'(a_fired), int'(ea));
         chk(b_fired == eb, "R3 fire decision B", int'(b_fired), int'(eb));
         chk(a_skipped == (trig_a && !ea), "R4 skip flag A", int'(a_skipped), int'(trig_a && !ea));
         chk(b_skipped == (trig_b && !eb), "R4 skip flag B", int'(b_skipped), int'(trig_b && !eb));
         chk(a_in_empty == {qa1.size() == 0, qa0.size() == 0}, "R1/R2 empty flags A",
             int'(a_in_empty), int'({qa1.size() == 0, qa0.size() == 0}));
         chk(a_in_full == {qa1.size() == 2, qa0.size() == 1}, "R1/R2 full flags A",
             int'(a_in_full), int'({qa1.size() == 2, qa0.size() == 1}));
         chk(b_in_full[0] == (qb0.size() == 1), "R1 full flag B",
             int'(b_in_full), int'(qb0.size() == 1));
         if (!trig_a && !trig_b)
            chk(!a_out_put && !b_out_put && !a_fired && !b_fired, "R5 no trigger no step",
                int'({a_out_put, b_out_put}), 0);

         va = '0; vb = '0;
         if (ea) begin
            va = acc_a + qa0[0] + qa1[0];
            chk(a_out_put && a_out_data == va, "R6 accumulate A", int'(a_out_data), int'(va));
            if (na < NREF)
               chk(a_out_data == ref_a[na], "R8 stream A", int'(a_out_data), int'(ref_a[na]));
            na++;
         end else begin
            chk(!a_out_put, "R4 no push on skip A", int'(a_out_put), 0);
         end
         if (eb) begin
            vb = acc_b + qb0[0];
            chk(b_out_put && b_out_data == vb, "R6 accumulate B", int'(b_out_data), int'(vb));
            if (nb < NREF)
               chk(b_out_data == ref_b[nb], "R8 stream B", int'(b_out_data), int'(ref_b[nb]));
            nb++;
         end else begin
            chk(!b_out_put, "R4 no push on skip B", int'(b_out_put), 0);
         end

         // apply the step: pops on pre-state, then pushes
         if (ea) begin void'(qa0.pop_front()); void'(qa1.pop_front()); acc_a = va; end
         if (eb) begin void'(qb0.pop_front()); acc_b = vb; end
         if (ea) qb0.push_back(va);
         if (eb) qa1.push_back(vb);
         if (src_put) begin qa0.push_back(src_data); sidx++; end
      end

      chk(na > 300, "R8 progress A", na, 300);
      chk(nb > 300, "R8 progress B", nb, 300);

      @(negedge clk);
      trig_a = 1'b0; trig_b = 1'b0; src_put = 1'b0;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule